// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block keeps one direct-mapped, write-back cache coherent with its peers on a shared snooping bus. Each line is Invalid, Valid (clean, unowned, maybe shared), Shared-Dirty (modified, owned, maybe shared) or Dirty (modified, owned, sole copy). The owner of a modified line, not memory, answers other caches' misses, so memory may stay stale while several caches hold the line.

The processor side takes one read or write at a time. A hit on a readable line completes locally. Anything that needs the bus raises a request and waits for a grant. The line's state is left untouched while it waits. Once granted, the controller drives a single-cycle transaction and completes it in the next cycle. A dirty or shared-dirty victim is written back as its own transaction before the fill.

The snoop side watches the other caches' transactions. It looks up the addressed line and answers one cycle later with an owner-supplies flag and the data word. In the same cycle it moves the line to its new state.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid: `bus_req`, `tx_valid` and `snp_supply` are 0, `cpu_ready` is 1, and snooped misses get no supply.
- R2: A read miss issues a transaction with `tx_op`=0 (read miss) for the request address. It returns `rsp_data` and leaves the line Valid. A later read of that address completes with no bus request.
- R3: A write hit on a Dirty line updates the data word with no bus transaction.
- R4: A write hit on a Valid or Shared-Dirty line issues `tx_op`=2 (invalidate) for the address, then leaves the line Dirty with the new data.
- R5: A write miss issues `tx_op`=1 (write miss) and leaves the line Dirty, holding the written word.
- R6: A snooped read miss (`snp_op`=0) that hits a Dirty or Shared-Dirty line raises `snp_supply` with the line's data one cycle later. A Dirty line becomes Shared-Dirty, so a later local write needs an invalidate.
- R7: A snooped transaction that hits a Valid line never raises `snp_supply`. A snooped write miss or invalidate (`snp_op`=2) moves the line to Invalid. A snoop whose tag differs leaves the line unchanged.
- R8: A snooped write miss (`snp_op`=1) that hits an owned line supplies its data and then invalidates it.
- R9: No transaction is driven and no line state changes before `bus_grant`. `tx_valid` rises only in the cycle after a grant.
- R10: A snoop to the pending request's index while it waits for the bus is handled first. The request drops `bus_req` and restarts from its lookup, so a write that was waiting to invalidate turns into a write miss.
- R11: A miss that evicts a Dirty or Shared-Dirty line first issues `tx_op`=3 (write-back) with the victim's address and data, then the fill. Evicting a Valid line issues only the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; the low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| tx_valid | output | 1 | Own transaction on the bus this cycle |
| tx_op | output | 2 | 0 read miss, 1 write miss, 2 invalidate, 3 write-back |
| tx_addr | output | ADDR_W | Transaction address |
| tx_data | output | DATA_W | Write-back data |
| rsp_data | input | DATA_W | Data returned for own miss (memory or owner) |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_op | input | 2 | Its type, encoded like `tx_op` |
| snp_addr | input | ADDR_W | Its address |
| snp_supply | output | 1 | This cache supplies data; memory must stay silent |
| snp_data | output | DATA_W | Supplied data word |

## Verification
Processor traffic is run through every starting line state: misses into an empty line, into a Valid victim and into an owned victim, and writes against Valid, Shared-Dirty and Dirty lines. The count and type of bus transactions separate the local-hit paths from the invalidate, miss and write-back paths. Snoops are sent against owned, clean, absent and tag-mismatched lines, so supply and invalidation can be told apart. Holding back the grant shows that nothing leaves the cache early. A snoop that lands on the waiting line shows the restart turning an invalidate into a write miss.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV     = 2'd0,
    LS_VALID   = 2'd1,
    LS_SHDIRTY = 2'd2,
    LS_DIRTY   = 2'd3
  } line_state_t;

  typedef enum logic [1:0] {
    BOP_RDMISS = 2'd0,
    BOP_WRMISS = 2'd1,
    BOP_INVAL  = 2'd2,
    BOP_WBACK  = 2'd3
  } bus_op_t;

  typedef enum logic [1:0] {
    F_IDLE   = 2'd0,
    F_LOOKUP = 2'd1,
    F_WAIT   = 2'd2,
    F_ISSUE  = 2'd3
  } fsm_t;

  function automatic logic is_owner(line_state_t s);
    return (s == LS_DIRTY) || (s == LS_SHDIRTY);
  endfunction
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output line_state_t       a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_state_t       b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              c_we_state,
  input  logic              c_we_line,
  input  logic [IDX_W-1:0]  c_idx,
  input  line_state_t       c_state,
  input  logic [TAG_W-1:0]  c_tag,
  input  logic [DATA_W-1:0] c_data,
  input  logic              s_we,
  input  logic [IDX_W-1:0]  s_idx,
  input  line_state_t       s_state
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];
  line_state_t       st_q     [LINES];

  // Tag and data carry no reset so they map onto plain RAM.
  always_ff @(posedge clk) begin
    if (c_we_line) begin
      tag_mem[c_idx]  <= c_tag;
      data_mem[c_idx] <= c_data;
    end
  end

  // State bits need a reset, so they live in flops, one per line.
  for (genvar g = 0; g < LINES; g++) begin : g_state
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    always_ff @(posedge clk) begin
      if (rst)
        st_q[g] <= LS_INV;
      else if (s_we && s_idx == GI)
        st_q[g] <= s_state;
      else if (c_we_state && c_idx == GI)
        st_q[g] <= c_state;
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_mem[a_idx];
  assign a_data  = data_mem[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_mem[b_idx];
  assign b_data  = data_mem[b_idx];

  // The request side stalls on an index collision, so the snoop and request writers never meet.
  assert_no_write_clash_R10: assert property (@(posedge clk) disable iff (rst)
    !(s_we && c_we_state && s_idx == c_idx));
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     snp_valid,
  input  logic [1:0]               snp_op,
  input  logic [ADDR_W-1:0]        snp_addr,
  output logic [IDX_W-1:0]         b_idx,
  input  line_state_t              b_state,
  input  logic [ADDR_W-IDX_W-1:0]  b_tag,
  input  logic [DATA_W-1:0]        b_data,
  output logic                     s_we,
  output logic [IDX_W-1:0]         s_idx,
  output line_state_t              s_state,
  output logic                     snp_supply,
  output logic [DATA_W-1:0]        snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  bus_op_t          op;
  logic [TAG_W-1:0] s_tag;
  logic             hit;
  logic             supply_d;

  assign op    = bus_op_t'(snp_op);
  assign b_idx = snp_addr[IDX_W-1:0];
  assign s_idx = b_idx;
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign hit   = snp_valid && (b_state != LS_INV) && (b_tag == s_tag);

  always_comb begin
    s_we     = 1'b0;
    s_state  = b_state;
    supply_d = 1'b0;
    if (hit) begin
      case (op)
        BOP_RDMISS: begin
          supply_d = is_owner(b_state);
          if (b_state == LS_DIRTY) begin
            s_we    = 1'b1;
            s_state = LS_SHDIRTY;
          end
        end
        BOP_WRMISS: begin
          supply_d = is_owner(b_state);
          s_we     = 1'b1;
          s_state  = LS_INV;
        end
        BOP_INVAL: begin
          s_we    = 1'b1;
          s_state = LS_INV;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_supply <= 1'b0;
      snp_data   <= '0;
    end else begin
      snp_supply <= supply_d;
      snp_data   <= b_data;
    end
  end

  // A supply answers only a snooped read or write miss in the cycle before.
  assert_supply_follows_miss_R6: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> ($past(snp_valid) && ($past(snp_op) == 2'd0 || $past(snp_op) == 2'd1)));
  assert_no_supply_on_inval_R7: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_op == 2'd2) |=> !snp_supply);
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  output logic                     cpu_ready,
  output logic                     cpu_done,
  output logic [DATA_W-1:0]        cpu_rdata,
  output logic                     bus_req,
  input  logic                     bus_grant,
  output logic                     tx_valid,
  output logic [1:0]               tx_op,
  output logic [ADDR_W-1:0]        tx_addr,
  output logic [DATA_W-1:0]        tx_data,
  input  logic [DATA_W-1:0]        rsp_data,
  input  logic                     snp_valid,
  input  logic [IDX_W-1:0]         snp_idx,
  output logic [IDX_W-1:0]         a_idx,
  input  line_state_t              a_state,
  input  logic [ADDR_W-IDX_W-1:0]  a_tag,
  input  logic [DATA_W-1:0]        a_data,
  output logic                     c_we_state,
  output logic                     c_we_line,
  output logic [IDX_W-1:0]         c_idx,
  output line_state_t              c_state,
  output logic [ADDR_W-IDX_W-1:0]  c_tag,
  output logic [DATA_W-1:0]        c_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_t              st;
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  bus_op_t           p_op;
  logic [TAG_W-1:0]  r_tag;
  logic [IDX_W-1:0]  r_idx;
  logic              hit, collide, local_wr;

  assign r_tag     = r_addr[ADDR_W-1:IDX_W];
  assign r_idx     = r_addr[IDX_W-1:0];
  assign a_idx     = r_idx;
  assign c_idx     = r_idx;
  assign c_tag     = r_tag;
  assign cpu_ready = (st == F_IDLE);
  assign hit       = (a_state != LS_INV) && (a_tag == r_tag);
  assign collide   = snp_valid && (snp_idx == r_idx);
  assign local_wr  = (st == F_LOOKUP) && !collide && hit && r_we && (a_state == LS_DIRTY);

  always_comb begin
    c_we_state = 1'b0;
    c_we_line  = 1'b0;
    c_state    = LS_INV;
    c_data     = r_wdata;
    if (local_wr) begin
      c_we_state = 1'b1;
      c_we_line  = 1'b1;
      c_state    = LS_DIRTY;
    end else if (st == F_ISSUE) begin
      c_we_state = 1'b1;
      case (p_op)
        BOP_WBACK: c_state = LS_INV;
        BOP_RDMISS: begin
          c_we_line = 1'b1;
          c_state   = LS_VALID;
          c_data    = rsp_data;
        end
        default: begin
          c_we_line = 1'b1;
          c_state   = LS_DIRTY;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= F_IDLE;
      r_we      <= 1'b0;
      r_addr    <= '0;
      r_wdata   <= '0;
      p_op      <= BOP_RDMISS;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      bus_req   <= 1'b0;
      tx_valid  <= 1'b0;
      tx_op     <= 2'd0;
      tx_addr   <= '0;
      tx_data   <= '0;
    end else begin
      cpu_done <= 1'b0;
      tx_valid <= 1'b0;
      case (st)
        F_IDLE: if (cpu_req) begin
          r_we    <= cpu_we;
          r_addr  <= cpu_addr;
          r_wdata <= cpu_wdata;
          st      <= F_LOOKUP;
        end
        F_LOOKUP: if (!collide) begin
          if (hit && !r_we) begin
            cpu_rdata <= a_data;
            cpu_done  <= 1'b1;
            st        <= F_IDLE;
          end else if (local_wr) begin
            cpu_done <= 1'b1;
            st       <= F_IDLE;
          end else begin
            if (hit)                   p_op <= BOP_INVAL;
            else if (is_owner(a_state)) p_op <= BOP_WBACK;
            else if (r_we)             p_op <= BOP_WRMISS;
            else                       p_op <= BOP_RDMISS;
            bus_req <= 1'b1;
            st      <= F_WAIT;
          end
        end
        F_WAIT: begin
          if (collide) begin
            bus_req <= 1'b0;
            st      <= F_LOOKUP;
          end else if (bus_grant) begin
            bus_req  <= 1'b0;
            tx_valid <= 1'b1;
            tx_op    <= p_op;
            tx_addr  <= (p_op == BOP_WBACK) ? {a_tag, r_idx} : r_addr;
            tx_data  <= (p_op == BOP_WBACK) ? a_data : r_wdata;
            st       <= F_ISSUE;
          end
        end
        F_ISSUE: begin
          if (p_op == BOP_WBACK) begin
            st <= F_LOOKUP;
          end else begin
            if (p_op == BOP_RDMISS) cpu_rdata <= rsp_data;
            cpu_done <= 1'b1;
            st       <= F_IDLE;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assert_tx_after_grant_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> ($past(bus_grant) && $past(bus_req)));
  assert_bus_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (!snp_valid && !bus_req));
  assert_dirty_write_silent_R3: assert property (@(posedge clk) disable iff (rst)
    local_wr |=> (cpu_done && !bus_req && !tx_valid));
  assert_inval_completes_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_op == 2'd2) |=> cpu_done);
  assert_wback_then_fill_R11: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_op == 2'd3) |=> (!cpu_done && !tx_valid));
  assert_restart_drops_req_R10: assert property (@(posedge clk) disable iff (rst)
    (st == F_WAIT && collide) |=> !bus_req);
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              tx_valid,
  output logic [1:0]        tx_op,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [DATA_W-1:0] tx_data,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx, c_idx, s_idx;
  line_state_t       a_state, b_state, c_state, s_state;
  logic [TAG_W-1:0]  a_tag, b_tag, c_tag;
  logic [DATA_W-1:0] a_data, b_data, c_data;
  logic              c_we_state, c_we_line, s_we;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
    .c_we_state(c_we_state), .c_we_line(c_we_line), .c_idx(c_idx),
    .c_state(c_state), .c_tag(c_tag), .c_data(c_data),
    .s_we(s_we), .s_idx(s_idx), .s_state(s_state)
  );

  coh_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
    .s_we(s_we), .s_idx(s_idx), .s_state(s_state),
    .snp_supply(snp_supply), .snp_data(snp_data)
  );

  coh_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .tx_valid(tx_valid), .tx_op(tx_op), .tx_addr(tx_addr), .tx_data(tx_data),
    .rsp_data(rsp_data),
    .snp_valid(snp_valid), .snp_idx(snp_addr[IDX_W-1:0]),
    .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .c_we_state(c_we_state), .c_we_line(c_we_line), .c_idx(c_idx),
    .c_state(c_state), .c_tag(c_tag), .c_data(c_data)
  );
endmodule

// File: tb/tb_snoop_coh_ctrl.sv
module tb_snoop_coh_ctrl;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 2;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic              cpu_ready, cpu_done;
  logic [DATA_W-1:0] cpu_rdata;
  logic              bus_req;
  logic              bus_grant = 1'b0;
  logic              tx_valid;
  logic [1:0]        tx_op;
  logic [ADDR_W-1:0] tx_addr;
  logic [DATA_W-1:0] tx_data;
  logic [DATA_W-1:0] rsp_data = '0;
  logic              snp_valid = 1'b0;
  logic [1:0]        snp_op = 2'd0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic              snp_supply;
  logic [DATA_W-1:0] snp_data;

  snoop_coh_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0, tx_cnt = 0;
  logic              gnt_en = 1'b1;
  logic [DATA_W-1:0] mem [256];
  logic [1:0]        lg_op   [16];
  logic [ADDR_W-1:0] lg_addr [16];
  logic [DATA_W-1:0] lg_data [16];

  // Bus model: grant, memory answer, transaction log
  always @(negedge clk) begin
    bus_grant <= gnt_en && bus_req;
    if (tx_valid) begin
      lg_op[tx_cnt % 16]   = tx_op;
      lg_addr[tx_cnt % 16] = tx_addr;
      lg_data[tx_cnt % 16] = tx_data;
      tx_cnt = tx_cnt + 1;
      if (tx_op == 2'd3) mem[tx_addr] = tx_data;
      rsp_data = mem[tx_addr];
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_start(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic cpu_finish(input string req, output logic [DATA_W-1:0] rd);
    bit got = 0;
    rd = '0;
    for (int i = 0; i < 100 && !got; i++) begin
      @(negedge clk);
      if (cpu_done) begin got = 1; rd = cpu_rdata; end
    end
    chk({req, " done"}, int'(got), 1);
  endtask

  task automatic cpu_op(input string req, input logic we, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] rd);
    cpu_start(we, a, d);
    cpu_finish(req, rd);
  endtask

  task automatic snoop(input logic [1:0] op, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  function automatic int last_op();   return int'(lg_op[(tx_cnt - 1) % 16]);   endfunction
  function automatic int last_addr(); return int'(lg_addr[(tx_cnt - 1) % 16]); endfunction

  task automatic t_reset_state();
    chk("R1 cpu_ready", int'(cpu_ready), 1);
    chk("R1 bus_req", int'(bus_req), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 snp_supply", int'(snp_supply), 0);
    snoop(2'd0, 8'h10);
    chk("R1 no supply from empty cache", int'(snp_supply), 0);
  endtask

  task automatic t_read_miss_hit();
    logic [DATA_W-1:0] rd; int t0 = tx_cnt;
    cpu_op("R2 miss", 0, 8'h04, '0, rd);
    chk("R2 one transaction", tx_cnt - t0, 1);
    chk("R2 read miss op", last_op(), 0);
    chk("R2 miss address", last_addr(), 'h04);
    chk("R2 fill data", int'(rd), 'hA004);
    t0 = tx_cnt;
    cpu_op("R2 hit", 0, 8'h04, '0, rd);
    chk("R2 hit has no bus traffic", tx_cnt - t0, 0);
    chk("R2 hit data", int'(rd), 'hA004);
  endtask

  task automatic t_write_paths();
    logic [DATA_W-1:0] rd; int t0 = tx_cnt;
    cpu_op("R4 write valid", 1, 8'h04, 16'h1111, rd);
    chk("R4 one invalidate", tx_cnt - t0, 1);
    chk("R4 invalidate op", last_op(), 2);
    chk("R4 invalidate address", last_addr(), 'h04);
    t0 = tx_cnt;
    cpu_op("R3 write dirty", 1, 8'h04, 16'h2222, rd);
    chk("R3 dirty write silent", tx_cnt - t0, 0);
    cpu_op("R3 readback", 0, 8'h04, '0, rd);
    chk("R3 readback data", int'(rd), 'h2222);
  endtask

  task automatic t_snoop_owner();
    logic [DATA_W-1:0] rd; int t0;
    snoop(2'd0, 8'h04);
    chk("R6 dirty owner supplies", int'(snp_supply), 1);
    chk("R6 supplied data", int'(snp_data), 'h2222);
    snoop(2'd0, 8'h04);
    chk("R6 shared-dirty still supplies", int'(snp_supply), 1);
    chk("R6 shared-dirty data", int'(snp_data), 'h2222);
    t0 = tx_cnt;
    cpu_op("R6 write shared-dirty", 1, 8'h04, 16'h3333, rd);
    chk("R6 shared-dirty write invalidates", tx_cnt - t0, 1);
    chk("R4 op from shared-dirty", last_op(), 2);
  endtask

  task automatic t_snoop_wrmiss();
    logic [DATA_W-1:0] rd; int t0;
    snoop(2'd1, 8'h04);
    chk("R8 owner supplies on write miss", int'(snp_supply), 1);
    chk("R8 supplied data", int'(snp_data), 'h3333);
    t0 = tx_cnt;
    cpu_op("R8 read after loss", 0, 8'h04, '0, rd);
    chk("R8 line was invalidated", tx_cnt - t0, 1);
    chk("R8 refetch op", last_op(), 0);
  endtask

  task automatic t_snoop_valid();
    logic [DATA_W-1:0] rd; int t0;
    snoop(2'd0, 8'h04);
    chk("R7 valid line never supplies", int'(snp_supply), 0);
    snoop(2'd0, 8'h08);
    chk("R7 tag mismatch no supply", int'(snp_supply), 0);
    snoop(2'd2, 8'h08);
    t0 = tx_cnt;
    cpu_op("R7 mismatch kept line", 0, 8'h04, '0, rd);
    chk("R7 line survives mismatched invalidate", tx_cnt - t0, 0);
    snoop(2'd2, 8'h04);
    chk("R7 no supply on invalidate", int'(snp_supply), 0);
    t0 = tx_cnt;
    cpu_op("R7 read after invalidate", 0, 8'h04, '0, rd);
    chk("R7 invalidate removed line", tx_cnt - t0, 1);
  endtask

  task automatic t_write_miss();
    logic [DATA_W-1:0] rd; int t0 = tx_cnt;
    cpu_op("R5 write miss", 1, 8'h05, 16'h5555, rd);
    chk("R5 one transaction", tx_cnt - t0, 1);
    chk("R5 write miss op", last_op(), 1);
    chk("R5 address", last_addr(), 'h05);
    t0 = tx_cnt;
    cpu_op("R5 readback", 0, 8'h05, '0, rd);
    chk("R5 line now held", tx_cnt - t0, 0);
    chk("R5 data", int'(rd), 'h5555);
    snoop(2'd0, 8'h05);
    chk("R5 line is owned", int'(snp_supply), 1);
  endtask

  task automatic t_evict();
    logic [DATA_W-1:0] rd; int t0 = tx_cnt;
    // 0x05 is Shared-Dirty after the snooped read above
    cpu_op("R11 owned evict", 0, 8'h09, '0, rd);
    chk("R11 write-back plus fill", tx_cnt - t0, 2);
    chk("R11 first is write-back", int'(lg_op[t0 % 16]), 3);
    chk("R11 victim address", int'(lg_addr[t0 % 16]), 'h05);
    chk("R11 victim data", int'(lg_data[t0 % 16]), 'h5555);
    chk("R11 then read miss", last_op(), 0);
    chk("R11 fill data", int'(rd), 'hA009);
    t0 = tx_cnt;
    cpu_op("R11 clean evict", 0, 8'h05, '0, rd);
    chk("R11 clean victim silent", tx_cnt - t0, 1);
    chk("R11 data from memory", int'(rd), 'h5555);
  endtask

  task automatic t_wait_grant();
    logic [DATA_W-1:0] rd; int t0 = tx_cnt;
    gnt_en = 1'b0;
    cpu_start(1, 8'h05, 16'h6666);
    repeat (4) @(negedge clk);
    chk("R9 request raised", int'(bus_req), 1);
    chk("R9 nothing driven before grant", tx_cnt - t0, 0);
    chk("R9 not complete before grant", int'(cpu_done), 0);
    snoop(2'd0, 8'h06);
    chk("R9 other line unaffected", int'(snp_supply), 0);
    gnt_en = 1'b1;
    cpu_finish("R9 granted", rd);
    chk("R9 invalidate after grant", last_op(), 2);
    snoop(2'd0, 8'h05);
    chk("R9 line owned after grant", int'(snp_supply), 1);
    chk("R9 owned data", int'(snp_data), 'h6666);
  endtask

  task automatic t_restart();
    logic [DATA_W-1:0] rd; int t0;
    cpu_op("R10 prefill", 0, 8'h0A, '0, rd);
    t0 = tx_cnt;
    gnt_en = 1'b0;
    cpu_start(1, 8'h0A, 16'h7777);
    repeat (3) @(negedge clk);
    chk("R10 waiting", int'(bus_req), 1);
    snoop(2'd2, 8'h0A);
    chk("R10 request dropped on restart", int'(bus_req), 0);
    gnt_en = 1'b1;
    cpu_finish("R10 restarted", rd);
    chk("R10 single transaction", tx_cnt - t0, 1);
    chk("R10 became write miss", last_op(), 1);
    chk("R10 address", last_addr(), 'h0A);
    t0 = tx_cnt;
    cpu_op("R10 readback", 0, 8'h0A, '0, rd);
    chk("R10 readback silent", tx_cnt - t0, 0);
    chk("R10 readback data", int'(rd), 'h7777);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + 16'(i);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_read_miss_hit();
    t_write_paths();
    t_snoop_owner();
    t_snoop_wrmiss();
    t_snoop_valid();
    t_write_miss();
    t_evict();
    t_wait_grant();
    t_restart();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule